// File: doc/BRIEF.md
# Dual Wiper Register File with Timed Non-Volatile Write

This block is the register core of a two-channel, 8-bit digital potentiometer. A serial front end decodes host transactions and hands each one over as a single-cycle command with a write flag, a 5-bit register address and a data byte. The front end raises the command in the cycle the transaction completes, which is when the host deselects the part. The block returns read data one cycle later. It drives two wiper codes, a per-channel shutdown flag and the output-type select for the serial data pin.

Each channel has a live wiper register and a stored start-up code. Both sit at the same address, and a mode bit in the control register chooses which one an access reaches. Thirteen general-purpose stored bytes complete the storage array. The array is modelled with flip-flops that the power-good input does not clear. Every write to stored data starts a self-timed busy period, whose length is a parameter counted in clocks. During that period the block turns away everything except polling reads of the control register.

When power-good falls, the block behaves as a power loss: the wipers return to midscale and the control register returns to its defaults. When power-good rises again, a parameterized delay runs, then each wiper is reloaded from its stored start-up code and the ready flag rises. Shutdown only overrides what the channels report and never alters the wiper codes.

Top module: `dpot_regfile`

## Requirements
- R1: While rst_n is low and afterwards until power-up, both wipers read 80h, ready, nv_busy, sdo_od and shdn_o are 0, the stored start-up codes are 80h and the general-purpose bytes are 00h.
- R2: While pwr_good is low the wipers are held at 80h and ready is 0. Ready rises exactly RECALL_CYC clock edges after pwr_good is sampled high, and in that same cycle each wiper takes its stored start-up code. Commands are ignored while ready is 0.
- R3: Address 00h is channel 0 and 01h is channel 1, 02h to 0Eh are general-purpose bytes and 10h is the control register. A read command gives rd_valid high with rd_data in the following cycle. A write command never raises rd_valid.
- R4: The control register has the mode bit at bit 7 (reset 0) and the shutdown-release bit at bit 6 (reset 1). Bit 5 is the read-only busy flag. Bit 1 selects the open-drain data output, resets to 0 and drives sdo_od. All other bits read 0.
- R5: With bit 7 set to 1, addresses 00h and 01h read and write only the live wiper, with no busy period. General-purpose reads then return 00h and general-purpose writes are dropped.
- R6: With bit 7 set to 0, a write to 00h or 01h stores the start-up code and also loads the live wiper. A read there returns the stored code and leaves the wiper unchanged.
- R7: Each write to stored data, either a start-up code or a general-purpose byte, holds nv_busy high for exactly WR_CYC cycles, beginning in the cycle after the command.
- R8: A command that arrives while nv_busy is high is handled as follows. Control-register reads return the register with bit 5 set. All writes are dropped and all other reads return 00h. A command in the last busy cycle is still refused, and one in the next cycle is accepted.
- R9: With bit 6 at 0, shdn_o is 2'b11 and both wiper codes keep their values. Setting bit 6 back to 1 gives shdn_o 2'b00 with the same codes.
- R10: Address 0Fh and addresses 11h to 1Fh ignore writes and read 00h.
- R11: A pwr_good low period keeps the stored bytes, returns the control register to 40h, and sets shdn_o and sdo_od to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, blanks the stored array |
| pwr_good | input | 1 | Supply-valid indication, low models a power loss |
| cmd_valid | input | 1 | Single-cycle command strobe from the serial front end |
| cmd_we | input | 1 | 1 for a write, 0 for a read |
| cmd_addr | input | 5 | Register address |
| cmd_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read response strobe, one cycle after a read command |
| rd_data | output | 8 | Read response data |
| wiper0 | output | 8 | Channel 0 wiper code |
| wiper1 | output | 8 | Channel 1 wiper code |
| shdn_o | output | 2 | Per-channel shutdown flag |
| sdo_od | output | 1 | Open-drain select for the serial data pin |
| nv_busy | output | 1 | Stored-data write in progress |
| ready | output | 1 | Power-up recall complete |

## Verification
Two things can meet in one cycle: a new command, and the expiry of the busy timer started by an earlier stored write. The bench times a control-register write so that it is captured in the last busy cycle, and sends a second write in the very next cycle. It then reads back the control register and the target byte, which must show the first write refused and the second accepted. A control-register poll placed inside the window must return bit 5 set. The bench also issues a read in the first clock after power-good rises, while the recall counter is running, and requires no response.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int DW      = 8;
  localparam int AW      = 5;
  localparam int NCH     = 2;
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int GP_LAST = 14;
  localparam int NV_N    = GP_LAST + 1;
  localparam int NV_AW   = $clog2(NV_N);

  localparam logic [AW-1:0] ADDR_CTRL = AW'(16);
  localparam logic [DW-1:0] CODE_MID  = DW'(1) << (DW - 1);

  localparam int BIT_MODE = 7;
  localparam int BIT_RUN  = 6;
  localparam int BIT_BUSY = 5;
  localparam int BIT_OD   = 1;

  localparam logic [DW-1:0] CTRL_RST  = DW'(1) << BIT_RUN;
  localparam logic [DW-1:0] CTRL_WMSK = (DW'(1) << BIT_MODE) | (DW'(1) << BIT_RUN) | (DW'(1) << BIT_OD);

  typedef logic [NCH-1:0][DW-1:0] code_vec_t;
endpackage

// File: rtl/dpot_nv_store.sv
module dpot_nv_store
  import dpot_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NV_AW-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [NV_AW-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output code_vec_t        start_codes
);
  logic [DW-1:0] cell_q [NV_N];

  for (genvar e = 0; e < NV_N; e++) begin : g_cell
    localparam logic [DW-1:0] BLANK = (e < NCH) ? CODE_MID : '0;
    logic hit;
    assign hit = wr_en && (wr_idx == NV_AW'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cell_q[e] <= BLANK;
      else if (hit) cell_q[e] <= wr_data;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_start
    assign start_codes[c] = cell_q[c];
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_idx) < NV_N) rd_data = cell_q[rd_idx];
  end
endmodule

// File: rtl/dpot_nv_timer.sv
module dpot_nv_timer #(
  parameter int WR_CYC = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy
);
  localparam int CW = $clog2(WR_CYC + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (abort)                cnt_d = '0;
    else if (start)           cnt_d = CW'(WR_CYC);
    else if (cnt_q != '0)     cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/dpot_recall_seq.sv
module dpot_recall_seq #(
  parameter int RECALL_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic recall_stb,
  output logic ready
);
  localparam int CW = $clog2(RECALL_CYC + 1);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rdy_q, rdy_d;

  assign recall_stb = pwr_good && !rdy_q && (cnt_q == CW'(RECALL_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (!pwr_good) begin
      cnt_d = '0;
      rdy_d = 1'b0;
    end else if (recall_stb) begin
      rdy_d = 1'b1;
    end else if (!rdy_q) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready = rdy_q;
endmodule

// File: rtl/dpot_regfile.sv
module dpot_regfile
  import dpot_pkg::*;
#(
  parameter int WR_CYC     = 2000000,
  parameter int RECALL_CYC = 500000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_good,
  input  logic          cmd_valid,
  input  logic          cmd_we,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] wiper0,
  output logic [DW-1:0] wiper1,
  output logic [NCH-1:0] shdn_o,
  output logic          sdo_od,
  output logic          nv_busy,
  output logic          ready
);
  code_vec_t     wpr_q, wpr_d;
  code_vec_t     start_codes;
  logic [DW-1:0] ctrl_q, ctrl_d;
  logic          rv_q, rv_d;
  logic [DW-1:0] rd_q, rd_d;

  logic          nv_we, tmr_start, recall_stb, busy;
  logic [DW-1:0] nv_rdata;
  logic          accept, mode_live;
  logic          hit_wpr, hit_gp, hit_ctrl;
  logic [CH_W-1:0] ch;

  dpot_recall_seq #(.RECALL_CYC(RECALL_CYC)) u_recall (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .recall_stb(recall_stb), .ready(ready)
  );

  dpot_nv_timer #(.WR_CYC(WR_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(tmr_start),
    .abort(!pwr_good), .busy(busy)
  );

  dpot_nv_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(nv_we),
    .wr_idx(cmd_addr[NV_AW-1:0]), .wr_data(cmd_wdata),
    .rd_idx(cmd_addr[NV_AW-1:0]), .rd_data(nv_rdata),
    .start_codes(start_codes)
  );

  // address decode
  assign hit_wpr  = (int'(cmd_addr) < NCH);
  assign hit_gp   = (int'(cmd_addr) >= NCH) && (int'(cmd_addr) <= GP_LAST);
  assign hit_ctrl = (cmd_addr == ADDR_CTRL);
  assign ch       = cmd_addr[CH_W-1:0];
  assign mode_live = ctrl_q[BIT_MODE];
  assign accept    = cmd_valid && ready && pwr_good;

  always_comb begin
    wpr_d     = wpr_q;
    ctrl_d    = ctrl_q;
    rv_d      = 1'b0;
    rd_d      = '0;
    nv_we     = 1'b0;
    tmr_start = 1'b0;
    if (!pwr_good) begin
      for (int c = 0; c < NCH; c++) wpr_d[c] = CODE_MID;
      ctrl_d = CTRL_RST;
    end else if (recall_stb) begin
      wpr_d = start_codes;
    end else if (accept) begin
      if (!cmd_we) begin
        rv_d = 1'b1;
        if (hit_ctrl) begin
          rd_d = ctrl_q;
          rd_d[BIT_BUSY] = busy;
        end else if (!busy) begin
          if (hit_wpr && mode_live)                rd_d = wpr_q[ch];
          else if ((hit_wpr || hit_gp) && !mode_live) rd_d = nv_rdata;
        end
      end else if (!busy) begin
        if (hit_ctrl) begin
          ctrl_d = cmd_wdata & CTRL_WMSK;
        end else if (hit_wpr && mode_live) begin
          wpr_d[ch] = cmd_wdata;
        end else if ((hit_wpr || hit_gp) && !mode_live) begin
          nv_we     = 1'b1;
          tmr_start = 1'b1;
          if (hit_wpr) wpr_d[ch] = cmd_wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) wpr_q[c] <= CODE_MID;
      ctrl_q <= CTRL_RST;
      rv_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      wpr_q  <= wpr_d;
      ctrl_q <= ctrl_d;
      rv_q   <= rv_d;
      rd_q   <= rd_d;
    end
  end

  assign wiper0   = wpr_q[0];
  assign wiper1   = wpr_q[1];
  assign shdn_o   = {NCH{~ctrl_q[BIT_RUN]}};
  assign sdo_od   = ctrl_q[BIT_OD];
  assign nv_busy  = busy;
  assign rd_valid = rv_q;
  assign rd_data  = rd_q;
endmodule

// File: rtl/dpot_regfile_chk.sv
module dpot_regfile_chk #(
  parameter int WR_CYC = 2000000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_good,
  input logic       cmd_valid,
  input logic       cmd_we,
  input logic [4:0] cmd_addr,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic [7:0] wiper0,
  input logic [7:0] wiper1,
  input logic       nv_busy,
  input logic       ready
);
  int run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= 0;
    else if (nv_busy) run_q <= run_q + 1;
    else              run_q <= 0;
  end

  // R2: power loss forces midscale and drops ready
  p_powerloss_mid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (wiper0 == 8'h80 && wiper1 == 8'h80 && !ready));

  // R3: every accepted read is answered next cycle
  p_read_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pwr_good && cmd_valid && !cmd_we) |=> rd_valid);

  // R3: writes never produce a read response
  p_write_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_we) |=> !rd_valid);

  // R7: busy window never longer than WR_CYC cycles
  p_busy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |-> (run_q < WR_CYC));

  // R8: writes during busy leave both wipers alone
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_busy && pwr_good && ready && cmd_valid && cmd_we) |=> ($stable(wiper0) && $stable(wiper1)));

  // R9: without a command or power event the codes hold, whatever shutdown does
  p_codes_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pwr_good && !cmd_valid) |=> ($stable(wiper0) && $stable(wiper1)));

  // R10: reserved and undefined addresses read zero
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pwr_good && cmd_valid && !cmd_we && (cmd_addr == 5'h0F || cmd_addr > 5'h10))
      |=> (rd_data == 8'h00));
endmodule

bind dpot_regfile dpot_regfile_chk #(.WR_CYC(WR_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cmd_valid(cmd_valid),
  .cmd_we(cmd_we), .cmd_addr(cmd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
  .wiper0(wiper0), .wiper1(wiper1), .nv_busy(nv_busy), .ready(ready)
);

// File: tb/tb_dpot_regfile.sv
module tb_dpot_regfile;
  localparam int WR = 16;
  localparam int RC = 8;

  logic clk = 1'b0;
  logic rst_n, pwr_good, cmd_valid, cmd_we;
  logic [4:0] cmd_addr;
  logic [7:0] cmd_wdata;
  logic rd_valid, sdo_od, nv_busy, ready;
  logic [7:0] rd_data, wiper0, wiper1;
  logic [1:0] shdn_o;

  int nvec = 0;
  int nfail = 0;

  logic [7:0] nv_m [15];
  logic [7:0] wp_m [2];
  logic [7:0] ctrl_m;

  always #5 clk = ~clk;

  dpot_regfile #(.WR_CYC(WR), .RECALL_CYC(RC)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cmd_valid(cmd_valid),
    .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .wiper0(wiper0), .wiper1(wiper1),
    .shdn_o(shdn_o), .sdo_od(sdo_od), .nv_busy(nv_busy), .ready(ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at a negedge, return at the next negedge after capture
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_we = 1'b1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d, output logic v);
    cmd_valid = 1'b1; cmd_we = 1'b0; cmd_addr = a; cmd_wdata = 8'h00;
    @(negedge clk);
    cmd_valid = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 1000 && nv_busy; g++) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_rd(input int a);
    logic live;
    live = ctrl_m[7];
    if (a == 16) return ctrl_m;
    if (a < 2)   return live ? wp_m[a] : nv_m[a];
    if (a < 15)  return live ? 8'h00 : nv_m[a];
    return 8'h00;
  endfunction

  function automatic logic [7:0] gp_pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic sweep(input string tag);
    logic [7:0] d; logic v;
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), d, v);
      chk({tag, " rd_valid"}, v, 1);
      chk(tag, d, exp_rd(a));
    end
  endtask

  task automatic power_up(input string tag);
    pwr_good = 1'b1;
    for (int k = 1; k <= RC; k++) begin
      if (k == 1) begin cmd_valid = 1'b1; cmd_we = 1'b0; cmd_addr = 5'h10; end
      @(negedge clk);
      if (k == 1) begin
        cmd_valid = 1'b0;
        chk({tag, " R2 cmd ignored before ready"}, rd_valid, 0);
      end
      chk({tag, " R2 ready timing"}, ready, (k == RC));
    end
    chk({tag, " R2 recall wiper0"}, wiper0, nv_m[0]);
    chk({tag, " R2 recall wiper1"}, wiper1, nv_m[1]);
    wp_m[0] = nv_m[0]; wp_m[1] = nv_m[1];
  endtask

  initial begin
    #1000000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d; logic v;
    int cnt;
    rst_n = 1'b0; pwr_good = 1'b0; cmd_valid = 1'b0; cmd_we = 1'b0;
    cmd_addr = '0; cmd_wdata = '0;
    for (int i = 0; i < 15; i++) nv_m[i] = (i < 2) ? 8'h80 : 8'h00;
    wp_m[0] = 8'h80; wp_m[1] = 8'h80; ctrl_m = 8'h40;
    repeat (3) @(negedge clk);
    chk("R1 wiper0", wiper0, 8'h80);
    chk("R1 wiper1", wiper1, 8'h80);
    chk("R1 ready", ready, 0);
    chk("R1 busy", nv_busy, 0);
    chk("R1 shdn", shdn_o, 0);
    chk("R1 sdo_od", sdo_od, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 held midscale", wiper0, 8'h80);
    power_up("first");
    rd(5'h10, d, v);
    chk("R4 control reset value", d, 8'h40);

    // stored writes in start-up mode (R6, R7)
    wr(5'd2, gp_pat(2)); nv_m[2] = gp_pat(2);
    cnt = 0;
    for (int g = 0; g < 1000 && nv_busy; g++) begin cnt++; @(negedge clk); end
    chk("R7 busy length", cnt, WR);
    for (int a = 3; a < 15; a++) begin
      wr(5'(a), gp_pat(a)); nv_m[a] = gp_pat(a);
      chk("R7 busy after stored write", nv_busy, 1);
      wait_idle();
    end
    wr(5'd0, 8'h3C); nv_m[0] = 8'h3C; wp_m[0] = 8'h3C;
    chk("R6 wiper0 follows start code", wiper0, 8'h3C);
    wait_idle();
    wr(5'd1, 8'hC5); nv_m[1] = 8'hC5; wp_m[1] = 8'hC5;
    chk("R6 wiper1 follows start code", wiper1, 8'hC5);
    wait_idle();
    sweep("R3 R6 R10 start-mode map");

    // live mode (R5)
    wr(5'h10, 8'hC0); ctrl_m = 8'hC0;
    wr(5'd0, 8'h11); wp_m[0] = 8'h11;
    chk("R5 no busy for live write", nv_busy, 0);
    wr(5'd1, 8'hEE); wp_m[1] = 8'hEE;
    chk("R5 wiper0", wiper0, 8'h11);
    chk("R5 wiper1", wiper1, 8'hEE);
    wr(5'd5, 8'h99);
    chk("R5 gp write dropped, no busy", nv_busy, 0);
    wr(5'h0F, 8'h55);
    wr(5'h15, 8'hAA);
    sweep("R5 R10 live-mode map");

    // shutdown (R9)
    wr(5'h10, 8'h80); ctrl_m = 8'h80;
    chk("R9 shutdown flags", shdn_o, 2'b11);
    chk("R9 wiper0 kept", wiper0, 8'h11);
    chk("R9 wiper1 kept", wiper1, 8'hEE);
    wr(5'h10, 8'hC0); ctrl_m = 8'hC0;
    chk("R9 released", shdn_o, 2'b00);
    chk("R9 wiper0 restored", wiper0, 8'h11);

    // control bits (R4)
    wr(5'h10, 8'hC2); ctrl_m = 8'hC2;
    chk("R4 sdo_od", sdo_od, 1);
    rd(5'h10, d, v);
    chk("R4 readback", d, 8'hC2);
    wr(5'h10, 8'hFF);
    rd(5'h10, d, v);
    chk("R4 unused bits read 0", d, 8'hC2);
    wr(5'h10, 8'h40); ctrl_m = 8'h40;

    // busy window and its closing cycle (R8)
    wr(5'd4, 8'hA5); nv_m[4] = 8'hA5;
    rd(5'h10, d, v);
    chk("R8 poll shows busy", d, 8'h60);
    rd(5'd4, d, v);
    chk("R8 other read during busy", d, 8'h00);
    repeat (WR - 3) @(negedge clk);
    wr(5'h10, 8'hC0);
    chk("R8 busy over after last cycle", nv_busy, 0);
    wr(5'd4, 8'h77); nv_m[4] = 8'h77;
    chk("R8 next write accepted", nv_busy, 1);
    wait_idle();
    rd(5'h10, d, v);
    chk("R8 write in last busy cycle dropped", d, 8'h40);
    rd(5'd4, d, v);
    chk("R8 gp after window", d, 8'h77);

    // power cycle (R11)
    wr(5'h10, 8'h82); ctrl_m = 8'h82;
    chk("R11 pre shdn", shdn_o, 2'b11);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R2 midscale on loss", wiper0, 8'h80);
    chk("R2 ready drop", ready, 0);
    chk("R11 shdn default", shdn_o, 2'b00);
    chk("R11 sdo default", sdo_od, 0);
    ctrl_m = 8'h40;
    repeat (3) @(negedge clk);
    power_up("second");
    sweep("R11 retained after power cycle");
    chk("R11 wiper0 from start code", wiper0, 8'h3C);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule